// File: doc/BRIEF.md
# Successive-Approximation Converter Controller

This block is the digital core of a 12-bit successive-approximation converter. It watches an active-low select line and a read/convert line. When both are low and the converter is idle, it starts a conversion: it freezes the sample by asserting the hold control, then works through one bit trial per clock, MSB first, on the capacitor-DAC code. An external comparator reports whether the held input is at or above the DAC level. The comparator, DAC, sample-hold and reference lie outside this block.

When the last trial is resolved, the result is written to an output register in two's complement. One clock later the ready flag returns high. The result is read through a 16-bit port made of two 8-bit lanes. The port is driven only while select is low and read/convert is high. A lane-swap input chooses which lane carries the high part of the result. Every data pin has its own drive enable, so the surrounding pad ring can form the three-state bus.

Top module: `sarc_top`

## Requirements
- R1: While `rdy_o` is high, a clock edge that sees `sel_n` low and `rdconv` low starts a conversion. In the cycle after that edge, `rdy_o` is 0, `hold_o` is 1 and `dac_o` is 0x800. If either input is high, no conversion starts.
- R2: Once a conversion has started, `rdy_o` stays low for exactly RES_W+1 cycles (13 cycles at the default width).
- R3: Any combination of `sel_n` and `rdconv` applied while `rdy_o` is low has no effect. The conversion keeps its length and its result.
- R4: If `sel_n` and `rdconv` are both still low when `rdy_o` returns high, `rdy_o` is high for one cycle only. A new conversion then starts at once, with `hold_o` high again.
- R5: When `sel_n` is 0 and `rdconv` is 1, `port_oe` is 0xFFFF. In any other combination, `port_oe` is 0x0000 and `port_q` reads 0x0000.
- R6: The result is 12-bit two's complement. The highest input gives 0x7FF, the input at the zero point gives 0x000, one step below zero gives 0xFFF, and the lowest input gives 0x800.
- R7: When `lane_sel` is 0, `port_q[15:8]` carries result bits 11..4, and `port_q[7:0]` carries result bits 3..0 followed by four zero bits.
- R8: When `lane_sel` is 1, `port_q[15:8]` carries result bits 3..0 followed by four zero bits, and `port_q[7:0]` carries result bits 11..4.
- R9: While a conversion runs, the port shows the previous result. The output register changes only on the final trial.
- R10: The trials run MSB first, one per clock. Each trial sets its bit in `dac_o` (an offset-binary code) and keeps the bit only if `cmp_i` is 1, meaning the input is at or above the DAC level. The result is the final DAC code with its MSB inverted.
- R11: `hold_o` is high during all the trial cycles. It is low in the single cycle after the output register is written, during which `rdy_o` is still low. `rdy_o` rises in the cycle after that one.
- R12: After reset, `rdy_o` is 1, `hold_o` is 0 and the stored result is 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low select |
| rdconv | input | 1 | Read (1) / convert (0) |
| lane_sel | input | 1 | Byte-lane swap select |
| cmp_i | input | 1 | Comparator: input at or above DAC level |
| rdy_o | output | 1 | High when idle, low while converting |
| hold_o | output | 1 | Sample-hold control, 1 = hold |
| dac_o | output | 12 | Trial code for the capacitor DAC (offset binary) |
| port_q | output | 16 | Output port data |
| port_oe | output | 16 | Per-bit drive enable of the port |

## Verification
A sequencer that skips or repeats a trial shows up the moment `rdy_o` rises. It changes both the length of the low period and the code read back, and a comparator model that tracks a known target makes every result bit depend on every trial. A bit-index or clear/set error in the trial logic corrupts `dac_o` within one cycle of the start, and the bench samples `dac_o` there. A stale or early write of the output register is caught during the conversion, because the port must still show the previous result. A steering error shows the first time a result is read in either lane order.

// File: rtl/sarc_pkg.sv
package sarc_pkg;
  localparam int unsigned RES_W_DEF  = 12;
  localparam int unsigned LANE_W_DEF = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TRIAL = 2'd1,
    ST_FIN   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/sarc_cmd.sv
module sarc_cmd (
  input  logic sel_n,
  input  logic rdconv,
  input  logic rdy_i,
  output logic start_o,
  output logic rd_en_o
);
  logic both_low;

  // level-triggered: OR of the two active-low lines gives the command
  always_comb begin
    both_low = ~(sel_n | rdconv);
    start_o  = both_low & rdy_i;
    rd_en_o  = ~sel_n & rdconv;
  end
endmodule

// File: rtl/sarc_seq.sv
module sarc_seq
  import sarc_pkg::*;
#(
  parameter int unsigned RES_W = RES_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] dac_o,
  output logic             hold_o,
  output logic             rdy_o,
  output logic             wr_o,
  output logic [RES_W-1:0] res_o
);
  localparam int unsigned IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;
  localparam logic [RES_W-1:0] ONE      = {{(RES_W-1){1'b0}}, 1'b1};
  localparam logic [RES_W-1:0] MSB_ONLY = ONE << (RES_W-1);
  localparam logic [IDX_W-1:0] IDX_TOP  = IDX_W'(RES_W-1);

  seq_state_e       state_q, state_d;
  logic [RES_W-1:0] code_q, code_d, kept;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             adv;

  always_comb begin
    kept    = code_q & ~((cmp_i ? '0 : ONE) << idx_q);
    state_d = state_q;
    code_d  = code_q;
    idx_d   = idx_q;
    wr_o    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_TRIAL;
          code_d  = MSB_ONLY;
          idx_d   = IDX_TOP;
        end
      end
      ST_TRIAL: begin
        if (idx_q == '0) begin
          state_d = ST_FIN;
          code_d  = kept;
          wr_o    = 1'b1;
        end else begin
          code_d = kept | (ONE << (idx_q - IDX_W'(1)));
          idx_d  = idx_q - IDX_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
    adv = (state_q != ST_IDLE) | start_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      code_q  <= '0;
      idx_q   <= '0;
    end else if (adv) begin
      state_q <= state_d;
      code_q  <= code_d;
      idx_q   <= idx_d;
    end
  end

  always_comb begin
    dac_o  = code_q;
    hold_o = (state_q == ST_TRIAL);
    rdy_o  = (state_q == ST_IDLE);
    res_o  = {~kept[RES_W-1], kept[RES_W-2:0]};
  end

  // R10: the first trial after the hold rises presents only the MSB
  a_r10_msb_trial_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_o) |-> (dac_o == MSB_ONLY));
endmodule

// File: rtl/sarc_port.sv
module sarc_port
  import sarc_pkg::*;
#(
  parameter int unsigned RES_W  = RES_W_DEF,
  parameter int unsigned LANE_W = LANE_W_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_i,
  input  logic [RES_W-1:0]    res_i,
  input  logic                rd_en_i,
  input  logic                lane_sel,
  output logic [2*LANE_W-1:0] port_q,
  output logic [2*LANE_W-1:0] port_oe
);
  localparam int unsigned PORT_W = 2 * LANE_W;
  localparam int unsigned LO_W   = RES_W - LANE_W;
  localparam int unsigned PAD_W  = LANE_W - LO_W;

  logic [RES_W-1:0]  res_q;
  logic [LANE_W-1:0] hi_part, lo_part;
  logic [PORT_W-1:0] steered;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    res_q <= '0;
    else if (wr_i) res_q <= res_i;
  end

  always_comb begin
    hi_part = res_q[RES_W-1 -: LANE_W];
    lo_part = {res_q[LO_W-1:0], {PAD_W{1'b0}}};
    steered = lane_sel ? {lo_part, hi_part} : {hi_part, lo_part};
  end

  for (genvar b = 0; b < PORT_W; b++) begin : g_pin
    assign port_oe[b] = rd_en_i;
    assign port_q[b]  = rd_en_i & steered[b];
  end

  // R5: the port is enabled as a whole or not at all
  a_r5_oe_all_or_none: assert property (@(posedge clk) disable iff (!rst_n)
    (port_oe == '0) || (&port_oe));
endmodule

// File: rtl/sarc_top.sv
module sarc_top
  import sarc_pkg::*;
#(
  parameter int unsigned RES_W  = RES_W_DEF,
  parameter int unsigned LANE_W = LANE_W_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel_n,
  input  logic                rdconv,
  input  logic                lane_sel,
  input  logic                cmp_i,
  output logic                rdy_o,
  output logic                hold_o,
  output logic [RES_W-1:0]    dac_o,
  output logic [2*LANE_W-1:0] port_q,
  output logic [2*LANE_W-1:0] port_oe
);
  logic             start, rd_en, wr;
  logic [RES_W-1:0] res;

  sarc_cmd u_cmd (
    .sel_n   (sel_n),
    .rdconv  (rdconv),
    .rdy_i   (rdy_o),
    .start_o (start),
    .rd_en_o (rd_en)
  );

  sarc_seq #(.RES_W(RES_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .cmp_i   (cmp_i),
    .dac_o   (dac_o),
    .hold_o  (hold_o),
    .rdy_o   (rdy_o),
    .wr_o    (wr),
    .res_o   (res)
  );

  sarc_port #(.RES_W(RES_W), .LANE_W(LANE_W)) u_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (wr),
    .res_i    (res),
    .rd_en_i  (rd_en),
    .lane_sel (lane_sel),
    .port_q   (port_q),
    .port_oe  (port_oe)
  );

  // R1: a command seen while ready starts a held conversion
  a_r1_start_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_o && !sel_n && !rdconv) |=> (!rdy_o && hold_o));

  // R11: after the write, one tracking cycle with ready still low
  a_r11_track_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (!rdy_o && !hold_o));

  // R11: ready only rises two cycles after a write
  a_r11_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_o) |-> $past(wr, 2));

  // R9: mid-conversion reads do not change
  a_r9_prev_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_o && $past(hold_o) && port_oe[0] && $past(port_oe[0]) && $stable(lane_sel))
      |-> $stable(port_q));
endmodule

// File: tb/sarc_top_tb_top.sv
module sarc_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RES_W = 12;

  typedef struct {
    logic [RES_W-1:0] code;
    logic             lane;
    logic             rd;
  } exp_t;

  logic clk, rst_n, sel_n, rdconv, lane_sel, cmp;
  logic rdy, hold;
  logic [RES_W-1:0] dac, off_tgt;
  logic [15:0] port_q, port_oe;

  int n_chk = 0;
  int n_err = 0;
  exp_t sb[$];
  logic prev_rdy;
  logic [RES_W-1:0] last_res;

  assign cmp = (dac <= off_tgt);

  sarc_top dut_i (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rdconv(rdconv),
    .lane_sel(lane_sel), .cmp_i(cmp), .rdy_o(rdy), .hold_o(hold),
    .dac_o(dac), .port_q(port_q), .port_oe(port_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] steer(input logic [RES_W-1:0] r, input logic ln);
    logic [7:0] hi, lo;
    hi = r[11:4];
    lo = {r[3:0], 4'b0000};
    return ln ? {lo, hi} : {hi, lo};
  endfunction

  // monitor: on each rising ready, compare the port against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (rdy && !prev_rdy && sb.size() > 0) begin
        exp_t it;
        it = sb.pop_front();
        if (it.rd)
          check(port_q == steer(it.code, it.lane), "R6/R7/R8 result on port",
                32'(port_q), 32'(steer(it.code, it.lane)));
      end
      prev_rdy = rdy;
    end else begin
      prev_rdy = 1'b1;
    end
  end

  // one conversion of a signed target code, read in read mode while busy
  task automatic convert(input logic [RES_W-1:0] code, input logic ln, input logic glitch);
    int cnt, fin;
    exp_t it;
    @(negedge clk); #1;
    off_tgt = code ^ 12'h800;
    lane_sel = ln;
    it.code = code; it.lane = ln; it.rd = 1'b1;
    sb.push_back(it);
    sel_n = 1'b0; rdconv = 1'b0;
    @(negedge clk);
    check(!rdy && hold, "R1 start", {30'd0, rdy, hold}, 32'h1);
    check(dac == 12'h800, "R10 first trial MSB", 32'(dac), 32'h800);
    #1 rdconv = 1'b1;
    cnt = 1; fin = 0;
    forever begin
      @(negedge clk);
      if (rdy) break;
      cnt++;
      if (!hold) fin++;
      if (cnt == 3)
        check(port_q == steer(last_res, ln), "R9 previous result", 32'(port_q),
              32'(steer(last_res, ln)));
      if (glitch && cnt == 4) begin #1 rdconv = 1'b0; end
      if (glitch && cnt == 6) begin #1 sel_n = 1'b1; end
      if (glitch && cnt == 7) begin #1 sel_n = 1'b0; rdconv = 1'b1; end
    end
    check(cnt == RES_W + 1, glitch ? "R3 busy length" : "R2 busy length", 32'(cnt),
          32'(RES_W + 1));
    check(fin == 1, "R11 one tracking cycle before ready", 32'(fin), 32'h1);
    last_res = code;
  endtask

  initial begin
    sel_n = 1'b1; rdconv = 1'b1; lane_sel = 1'b0; off_tgt = '0;
    rst_n = 1'b0;
    last_res = '0;
    repeat (3) @(negedge clk);
    check(rdy && !hold, "R12 reset state", {30'd0, rdy, hold}, 32'h2);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(port_oe == 16'h0 && port_q == 16'h0, "R5 deselected", 32'(port_oe), 32'h0);
    #1 sel_n = 1'b0;
    @(negedge clk);
    check(port_oe == 16'hFFFF, "R5 read enabled", 32'(port_oe), 32'hFFFF);
    check(port_q == 16'h0, "R12 reset result", 32'(port_q), 32'h0);
    #1 sel_n = 1'b1; rdconv = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(rdy && !hold, "R1 no start when deselected", {30'd0, rdy, hold}, 32'h2);
    check(port_oe == 16'h0 && port_q == 16'h0, "R5 convert mode undriven",
          32'(port_q), 32'h0);
    #1 rdconv = 1'b1; sel_n = 1'b0;

    convert(12'h7FF, 1'b0, 1'b0);  // R6 positive full scale
    convert(12'h000, 1'b0, 1'b0);  // R6 zero
    convert(12'hFFF, 1'b1, 1'b0);  // R6 one step below zero, R8
    convert(12'h800, 1'b0, 1'b0);  // R6 negative full scale, R7
    convert(12'h123, 1'b1, 1'b0);  // R8, R10
    convert(12'hA5C, 1'b0, 1'b1);  // R3 commands while busy

    // R4 restart: keep the convert command held through the end
    begin
      exp_t it;
      @(negedge clk); #1;
      off_tgt = 12'h3C6 ^ 12'h800;
      lane_sel = 1'b0;
      it.code = 12'h3C6; it.lane = 1'b0; it.rd = 1'b0;
      sb.push_back(it);
      sb.push_back(it);
      rdconv = 1'b0;
      do @(negedge clk); while (rdy);
      do @(negedge clk); while (!rdy);
      @(negedge clk);
      check(!rdy && hold, "R4 immediate restart", {30'd0, rdy, hold}, 32'h1);
      #1 rdconv = 1'b1;
      do @(negedge clk); while (!rdy);
      check(port_q == steer(12'h3C6, 1'b0), "R4 restart result", 32'(port_q),
            32'(steer(12'h3C6, 1'b0)));
      last_res = 12'h3C6;
    end

    convert(12'h4B1, 1'b1, 1'b0);
    #1 lane_sel = 1'b0;
    @(negedge clk);
    check(port_q == steer(12'h4B1, 1'b0), "R7 lane order after swap back",
          32'(port_q), 32'(steer(12'h4B1, 1'b0)));
    check(sb.size() == 0, "R2 all conversions completed", 32'(sb.size()), 32'h0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog R2 run did not finish actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule